// File: doc/BRIEF.md
# Narrow-Write Register Access Bridge

This bridge connects a host that issues 8-, 16- and 32-bit register reads and writes to a peripheral register file that accepts only aligned 32-bit accesses. A narrow read becomes a single 32-bit downstream read. The addressed lane is then extracted and returned zero-extended. A narrow write becomes a downstream read, a lane merge and a downstream write of the merged word. A full-word write goes straight through as one downstream write.

Two registers in the same aligned word need special handling. A halfword write to the transfer-mode offset is not sent downstream. The bridge merges it into the current word and keeps the result in an internal shadow word. A later halfword write to the command offset skips the downstream read. It inserts the command into the shadow word and sends one 32-bit write that carries both halfwords.

The peripheral loses writes that arrive too close together. For that reason, every downstream write is held back until a programmed number of microsecond ticks has elapsed since the previous downstream write completed. Reads are never held back. The host sees one request at a time. Its ready signal stays low for the whole sequence, including any pacing stall.

Top module: `lane_rmw_bridge`

## Requirements
- R1: Every downstream access is 32 bits wide, at the request address with bits 1:0 forced to zero.
- R2: The access size is encoded as 0 = byte, 1 = halfword, 2 or 3 = word. A read issues exactly one downstream read and returns the addressed lane zero-extended. A halfword uses bits 15:0 when address bit 1 is 0 and bits 31:16 when it is 1. A byte uses the lane at bit offset 8 times address bits 1:0.
- R3: A byte or halfword write (other than the two special halfwords) issues one downstream read and then one downstream write. The write carries the old word with only the addressed lane replaced.
- R4: A halfword write to the transfer-mode offset (default 0x0C) issues one downstream read and no downstream write. The merged word is stored in the shadow word, and the peripheral word is left unchanged.
- R5: A halfword write to the command offset (default 0x0E) issues no downstream read. It issues one downstream write of the shadow word with bits 31:16 replaced by the command.
- R6: A downstream write is not presented until at least GAP_US ticks (default 6) have been seen since the previous downstream write completed. Reads are not delayed by this gap.
- R7: After reset the tick count since the last write is zero, so the first downstream write also waits GAP_US ticks. The shadow word resets to zero.
- R8: A 32-bit host write issues exactly one downstream write of the host data and no downstream read.
- R9: The host ready signal is low while an access is in progress and pulses high for exactly one cycle when it finishes. Read data is valid in that cycle. While a downstream request waits for its ready, the downstream address, data and direction stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| host_valid | input | 1 | Host request present; held until host_ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| host_addr | input | AW | Byte address of the register |
| host_wdata | input | DW | Write data, right-aligned |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | DW | Zero-extended read data, valid with host_ready |
| dn_valid | output | 1 | Downstream request |
| dn_write | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | AW | Word-aligned downstream address |
| dn_wdata | output | DW | Downstream write word |
| dn_ready | input | 1 | Downstream completion |
| dn_rdata | input | DW | Downstream read word, valid with dn_ready |

## Verification
Three properties are checked on every cycle by assertions. First, downstream addresses are aligned and requests stay stable while they wait. Second, the host ready pulse lasts one cycle and the pacing counter never exceeds its limit. Third, command and full-word writes never issue a downstream read, and a transfer-mode write never reaches the peripheral. Some behaviour can only be shown by the bench scenarios, because it needs a model of the peripheral contents and of elapsed ticks:
- the merged word contents;
- the combined command/transfer-mode word;
- the zero shadow after reset;
- that every write waits the full gap while a read issued just after a write completes quickly.

// File: rtl/lane_rmw_pkg.sv
package lane_rmw_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROUTE,
        ST_FETCH,
        ST_STORE,
        ST_DONE
    } bridge_state_e;

endpackage

// File: rtl/lane_merge.sv
module lane_merge #(
    parameter int DW = 32
) (
    input  logic [1:0]    size,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] old_word,
    input  logic [DW-1:0] new_data,
    output logic [DW-1:0] merged,
    output logic [DW-1:0] extracted
);
    import lane_rmw_pkg::*;

    localparam int SHW    = $clog2(DW);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    logic [SHW-1:0] shift;
    logic [DW-1:0]  mask;
    logic [DW-1:0]  placed;

    always_comb begin
        if (size == SZ_BYTE) begin
            shift = SHW'(sel) * SHW'(BYTE_W);
            mask  = {{(DW-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
        end else if (size == SZ_HALF) begin
            shift = SHW'(sel[1]) * SHW'(HALF_W);
            mask  = {{(DW-HALF_W){1'b0}}, {HALF_W{1'b1}}};
        end else begin
            shift = '0;
            mask  = '1;
        end
        placed    = mask << shift;
        merged    = (old_word & ~placed) | ((new_data & mask) << shift);
        extracted = (old_word >> shift) & mask;
    end

endmodule

// File: rtl/write_pacer.sv
module write_pacer #(
    parameter int GAP_US = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic ok
);
    localparam int CW = $clog2(GAP_US + 2);
    localparam logic [CW-1:0] LIMIT = CW'(GAP_US);

    logic [CW-1:0] elapsed_d, elapsed_q;

    always_comb begin
        elapsed_d = elapsed_q;
        if (restart)
            elapsed_d = '0;
        else if (tick && elapsed_q < LIMIT)
            elapsed_d = elapsed_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) elapsed_q <= '0;
        else        elapsed_q <= elapsed_d;
    end

    assign ok = (elapsed_q >= LIMIT);

    // R6: saturating counter never passes its limit
    p_elapsed_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed_q <= LIMIT);
    // R6: a completed write restarts the measurement
    p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> elapsed_q == '0);

endmodule

// File: rtl/lane_rmw_bridge.sv
module lane_rmw_bridge #(
    parameter int AW       = 8,
    parameter int DW       = 32,
    parameter int GAP_US   = 6,
    parameter int XFER_OFS = 'h0C,
    parameter int CMD_OFS  = 'h0E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          us_tick,
    input  logic          host_valid,
    input  logic          host_write,
    input  logic [1:0]    host_size,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_ready,
    output logic [DW-1:0] host_rdata,
    output logic          dn_valid,
    output logic          dn_write,
    output logic [AW-1:0] dn_addr,
    output logic [DW-1:0] dn_wdata,
    input  logic          dn_ready,
    input  logic [DW-1:0] dn_rdata
);
    import lane_rmw_pkg::*;

    localparam logic [AW-1:0] XFER_A = AW'(XFER_OFS);
    localparam logic [AW-1:0] CMD_A  = AW'(CMD_OFS);

    typedef struct packed {
        bridge_state_e st;
        logic          wr;
        logic [1:0]    sz;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] word;
        logic [DW-1:0] shadow;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          pace_ok;
    logic          wr_done;
    logic [DW-1:0] merge_old, merged, extracted;
    logic          is_half, is_word, tm_hit, cmd_hit;

    assign is_half = (ctl_q.sz == SZ_HALF);
    assign is_word = ctl_q.sz[1];
    assign tm_hit  = ctl_q.wr && is_half && (ctl_q.addr == XFER_A);
    assign cmd_hit = ctl_q.wr && is_half && (ctl_q.addr == CMD_A);

    assign merge_old = (ctl_q.st == ST_FETCH) ? dn_rdata : ctl_q.shadow;

    lane_merge #(.DW(DW)) merge_i (
        .size      (ctl_q.sz),
        .sel       (ctl_q.addr[1:0]),
        .old_word  (merge_old),
        .new_data  (ctl_q.wdata),
        .merged    (merged),
        .extracted (extracted)
    );

    write_pacer #(.GAP_US(GAP_US)) pacer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (us_tick),
        .restart (wr_done),
        .ok      (pace_ok)
    );

    always_comb begin
        ctl_d      = ctl_q;
        dn_valid   = 1'b0;
        dn_write   = 1'b0;
        dn_addr    = {ctl_q.addr[AW-1:2], 2'b00};
        dn_wdata   = ctl_q.word;
        host_ready = 1'b0;
        wr_done    = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (host_valid) begin
                    ctl_d.wr    = host_write;
                    ctl_d.sz    = host_size;
                    ctl_d.addr  = host_addr;
                    ctl_d.wdata = host_wdata;
                    ctl_d.st    = ST_ROUTE;
                end
            end
            ST_ROUTE: begin
                if (ctl_q.wr && is_word) begin
                    ctl_d.word = ctl_q.wdata;
                    ctl_d.st   = ST_STORE;
                end else if (cmd_hit) begin
                    ctl_d.word = merged;
                    ctl_d.st   = ST_STORE;
                end else begin
                    ctl_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                dn_valid = 1'b1;
                if (dn_ready) begin
                    if (!ctl_q.wr) begin
                        ctl_d.word = extracted;
                        ctl_d.st   = ST_DONE;
                    end else if (tm_hit) begin
                        ctl_d.shadow = merged;
                        ctl_d.st     = ST_DONE;
                    end else begin
                        ctl_d.word = merged;
                        ctl_d.st   = ST_STORE;
                    end
                end
            end
            ST_STORE: begin
                dn_valid = pace_ok;
                dn_write = 1'b1;
                if (pace_ok && dn_ready) begin
                    wr_done  = 1'b1;
                    ctl_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                host_ready = 1'b1;
                ctl_d.st   = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.st     <= ST_IDLE;
        end else begin
            ctl_q        <= ctl_d;
        end
    end

    assign host_rdata = ctl_q.word;

    // R1: downstream accesses are word aligned
    p_dn_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> dn_addr[1:0] == 2'b00);
    // R9: a waiting downstream request holds its fields
    p_dn_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr)
                                      && $stable(dn_wdata) && $stable(dn_write)));
    // R9: completion is a single-cycle pulse
    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);
    // R4: transfer-mode halfword never reaches the peripheral
    p_tm_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_write) |-> !tm_hit);
    // R5: command halfword is never preceded by a downstream read
    p_cmd_noread_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_write) |-> !cmd_hit);
    // R8: full-word writes never read downstream
    p_word_noread_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_write) |-> !(ctl_q.wr && is_word));
    // R6: a downstream write is only presented once the gap has elapsed
    p_write_paced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_write) |-> pace_ok);

endmodule

// File: tb/lane_rmw_bridge_tb_top.sv
module lane_rmw_bridge_tb_top;

    localparam int AW  = 8;
    localparam int DW  = 32;
    localparam int GAP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          us_tick = 1'b0;
    logic          host_valid = 1'b0;
    logic          host_write = 1'b0;
    logic [1:0]    host_size = 2'd0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ready;
    logic [DW-1:0] host_rdata;
    logic          dn_valid, dn_write;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_wdata;
    logic          dn_ready;
    logic [DW-1:0] dn_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int n_rd    = 0;
    int n_wr    = 0;

    always #2.5 clk = ~clk;

    lane_rmw_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .host_valid(host_valid), .host_write(host_write), .host_size(host_size),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rdata(host_rdata),
        .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr),
        .dn_wdata(dn_wdata), .dn_ready(dn_ready), .dn_rdata(dn_rdata)
    );

    // peripheral model: 16 words, ready one cycle after request
    logic [DW-1:0] pmem [16];
    logic          prdy = 1'b0;
    assign dn_ready = prdy;
    assign dn_rdata = pmem[dn_addr[5:2]];

    always @(posedge clk) begin
        prdy <= dn_valid && !prdy;
        if (dn_valid && prdy) begin
            if (dn_write) begin
                pmem[dn_addr[5:2]] <= dn_wdata;
                n_wr <= n_wr + 1;
            end else begin
                n_rd <= n_rd + 1;
            end
        end
    end

    logic [DW-1:0] model [16];
    logic [DW-1:0] shadow_m = '0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bmerge(input logic [31:0] old, input logic [1:0] sz,
                                           input logic [7:0] a, input logic [31:0] d);
        logic [31:0] r = old;
        if (sz == 2'd0)      r[a[1:0]*8 +: 8]   = d[7:0];
        else if (sz == 2'd1) r[a[1]*16 +: 16]   = d[15:0];
        else                 r = d;
        return r;
    endfunction

    function automatic logic [31:0] bextract(input logic [31:0] w, input logic [1:0] sz, input logic [7:0] a);
        if (sz == 2'd0)      return {24'h0, w[a[1:0]*8 +: 8]};
        else if (sz == 2'd1) return {16'h0, w[a[1]*16 +: 16]};
        return w;
    endfunction

    // scoreboard queues
    logic        q_rd  [$];
    logic [31:0] q_exp [$];
    string       q_tag [$];

    // monitor: compare results and ready pulse width
    logic prev_ready = 1'b0;
    initial forever begin
        @(negedge clk);
        if (rst_n && host_ready) begin
            chk(!prev_ready, "R9 ready pulse width", 32'(prev_ready), 32'h0);
            if (q_rd.size() == 0) begin
                chk(1'b0, "R9 unexpected completion", 32'h1, 32'h0);
            end else begin
                logic        r  = q_rd.pop_front();
                logic [31:0] e  = q_exp.pop_front();
                string       t  = q_tag.pop_front();
                if (r) chk(host_rdata === e, t, host_rdata, e);
            end
        end
        prev_ready = host_ready;
    end

    // tick source and independent pacing monitor
    int el = 0;
    int tcnt = 0;
    initial forever begin
        @(negedge clk);
        if (!rst_n) begin
            el = 0;
        end else if (dn_valid && dn_ready && dn_write) begin
            chk(el >= GAP, "R6/R7 write gap ticks", 32'(el), 32'(GAP));
            el = 0;
        end else if (us_tick && el < 1000) begin
            el++;
        end
        tcnt = (tcnt + 1) % 5;
        us_tick = (tcnt == 0);
    end

    task automatic access(input logic wr, input logic [1:0] sz, input logic [7:0] a,
                          input logic [31:0] wd, input logic [31:0] exp, input string tag,
                          input int exp_rd, input int exp_wr, output int lat);
        int rd0 = n_rd;
        int wr0 = n_wr;
        q_rd.push_back(!wr);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_size = sz; host_addr = a; host_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_ready);
        host_valid = 1'b0;
        chk(n_rd - rd0 == exp_rd, {tag, " downstream reads"}, 32'(n_rd - rd0), 32'(exp_rd));
        chk(n_wr - wr0 == exp_wr, {tag, " downstream writes"}, 32'(n_wr - wr0), 32'(exp_wr));
    endtask

    task automatic rd(input logic [1:0] sz, input logic [7:0] a, input string tag);
        int lat;
        access(1'b0, sz, a, 32'h0, bextract(model[a[5:2]], sz, a), tag, 1, 0, lat);
    endtask

    task automatic wr_plain(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d, input string tag);
        int lat;
        access(1'b1, sz, a, d, 32'h0, tag, (sz[1] ? 0 : 1), 1, lat);
        model[a[5:2]] = bmerge(model[a[5:2]], sz, a, d);
    endtask

    initial begin
        int lat;
        for (int i = 0; i < 16; i++) begin
            pmem[i]  = 32'h11223344 ^ (32'(i) * 32'h01030507);
            model[i] = 32'h11223344 ^ (32'(i) * 32'h01030507);
        end
        repeat (4) @(negedge clk);
        chk(host_ready == 1'b0 && dn_valid == 1'b0, "R9 reset outputs idle", {host_ready, dn_valid}, 32'h0);
        rst_n = 1'b1;

        // R7/R5: command write before any transfer-mode write merges zero shadow
        access(1'b1, 2'd1, 8'h0E, 32'h0000BEEF, 32'h0, "R5 cmd first", 0, 1, lat);
        model[3] = {16'hBEEF, 16'h0000};
        rd(2'd2, 8'h0C, "R7 shadow zero after reset");

        // R1/R2 reads of every lane width
        rd(2'd2, 8'h04, "R2 word read");
        rd(2'd3, 8'h07, "R1 word read unaligned addr");
        rd(2'd1, 8'h06, "R2 half read upper");
        rd(2'd1, 8'h04, "R2 half read lower");
        rd(2'd0, 8'h09, "R2 byte lane1");
        rd(2'd0, 8'h0B, "R2 byte lane3");

        // R8 word write passthrough
        wr_plain(2'd2, 8'h10, 32'hCAFEF00D, "R8 word write");
        rd(2'd2, 8'h10, "R8 word readback");

        // R3 narrow read-modify-write
        wr_plain(2'd0, 8'h11, 32'h000000A5, "R3 byte write");
        rd(2'd2, 8'h10, "R3 byte merge readback");
        wr_plain(2'd1, 8'h16, 32'h00005A5A, "R3 half write");
        rd(2'd2, 8'h14, "R3 half merge readback");

        // R6: read right after a write is not paced
        wr_plain(2'd0, 8'h20, 32'h00000077, "R6 write before read");
        access(1'b0, 2'd2, 8'h20, 32'h0, model[8], "R6 read after write", 1, 0, lat);
        chk(lat <= 8, "R6 read latency not paced", 32'(lat), 32'd8);

        // R6: back-to-back writes each wait the gap (pacing monitor)
        wr_plain(2'd2, 8'h24, 32'h01010101, "R6 burst write a");
        wr_plain(2'd2, 8'h28, 32'h02020202, "R6 burst write b");
        access(1'b0, 2'd2, 8'h28, 32'h0, 32'h02020202, "R6 burst readback", 1, 0, lat);

        // R4 transfer-mode halfword goes to shadow only
        access(1'b1, 2'd1, 8'h0C, 32'h00001234, 32'h0, "R4 tm write", 1, 0, lat);
        shadow_m = bmerge(model[3], 2'd1, 8'h0C, 32'h1234);
        rd(2'd2, 8'h0C, "R4 peripheral word unchanged");

        // R5 command write carries both halfwords
        access(1'b1, 2'd1, 8'h0E, 32'h0000ABCD, 32'h0, "R5 cmd write", 0, 1, lat);
        model[3] = {16'hABCD, shadow_m[15:0]};
        rd(2'd2, 8'h0C, "R5 combined word");
        rd(2'd0, 8'h0D, "R2 byte of combined word");

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule